// File: doc/BRIEF.md
# Carrier Tracking Loop Filter with Frequency Assist

This block is the second-order filter of a carrier recovery loop. Each time an update strobe arrives with a signed carrier phase-error sample, it does four things. It forms a proportional ("lead") term from that sample. It advances an integrating ("lag") accumulator. It adds the two into a frequency correction word. It presents that word on a registered output with a one-cycle valid pulse. Gains, limits and mode selections are static register inputs that a host holds steady while the loop runs.

The lag accumulator can also take three further contributions. The first is a frequency-error term from a built-in differencing discriminator. That discriminator compares the present phase error with the one seen a selectable power-of-two number of updates earlier. It is gated by an enable bit and scaled by one of two gains, picked by the acquire/track mode. The second is a sweep increment added on every update during continuous acquisition sweeping. The third is the same increment added only when an external lock-timeout pulse arrives, during stepped acquisition. The accumulator saturates at programmable signed limits, and it can be preset through a load port.

A two-state controller sequences the output. In `ST_IDLE` no word is being presented. The transition `T_UPDATE` (an accepted strobe) moves to, or stays in, `ST_OUT`, where `valid_o` is high. The transition `T_RETIRE` (no accepted strobe) returns to `ST_IDLE`.

Top module: `carrier_loop_afc`

## Requirements
- R1: A synchronous active-low reset clears the lag accumulator, the discriminator history, `freq_o` and `valid_o` to zero.
- R2: A strobe is accepted when `upd_i` is 1 and `load_i` is 0. `valid_o` is 1 in exactly the cycle after each accepted strobe and 0 otherwise. `freq_o` changes only on accepted strobes.
- R3: On an accepted strobe, `freq_o` becomes the new lag value plus (klead × err) >>> 8, saturated to the signed `LAG_W+1`-bit range.
- R4: Every accepted strobe adds (klag × err) >>> 8 to the lag accumulator. Gains are unsigned, and >>> is an arithmetic shift that rounds toward minus infinity.
- R5: The frequency error is err minus the err of D accepted strobes earlier. History before reset counts as zero. D is 2^code for `dly_code_i` 0..4, and codes 5..7 act as code 4 (D = 16).
- R6: With `afc_en_i` = 1, each accepted strobe adds (G × frequency error) >>> 8 to the lag. G is `afc_gain_acq_i` when `trk_mode_i` = 0 (acquire) and `afc_gain_trk_i` when `trk_mode_i` = 1 (track). With `afc_en_i` = 0 this term is zero in both modes.
- R7: A zero gain for one mode removes the frequency-error term in that mode only. The other mode's gain still applies.
- R8: With `sweep_sel_i` = 1 (continuous) and acquire mode, `sweep_inc_i` is added to the lag on every accepted strobe. In track mode no sweep is added.
- R9: With `sweep_sel_i` = 2 (stepped) and acquire mode, `sweep_inc_i` is added only in the clock where `tmo_i` is 1, even without a strobe. Strobes alone add no sweep, and `valid_o` stays 0 for a lone timeout. Codes 0 and 3 add no sweep. The lag is unchanged in any cycle with no strobe, no load and no timeout.
- R10: After each update the lag is clamped to [`lag_lo_i`, `lag_hi_i`], saturating instead of wrapping.
- R11: `load_i` = 1 sets the lag to `load_val_i` in the next cycle. Load has priority: a strobe in the same cycle is dropped, with no valid pulse and no history shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_i | input | 1 | Loop update strobe |
| err_i | input | ERR_W | Signed carrier phase error |
| load_i | input | 1 | Preset lag accumulator |
| load_val_i | input | LAG_W | Signed preset value |
| tmo_i | input | 1 | Lock-timeout pulse |
| trk_mode_i | input | 1 | 0 acquire, 1 track |
| afc_en_i | input | 1 | Frequency-error term enable |
| afc_gain_acq_i | input | GAIN_W | Frequency-error gain, acquire |
| afc_gain_trk_i | input | GAIN_W | Frequency-error gain, track |
| dly_code_i | input | 3 | Discriminator delay code |
| sweep_sel_i | input | 2 | 0 off, 1 continuous, 2 stepped, 3 off |
| sweep_inc_i | input | SWP_W | Signed sweep increment |
| klag_i | input | GAIN_W | Integrator gain |
| klead_i | input | GAIN_W | Proportional gain |
| lag_hi_i | input | LAG_W | Signed upper lag limit |
| lag_lo_i | input | LAG_W | Signed lower lag limit |
| freq_o | output | LAG_W+1 | Frequency correction word |
| lag_o | output | LAG_W | Present lag accumulator value |
| valid_o | output | 1 | Output valid pulse |

## Verification
The limit-range assertion assumes `lag_lo_i` never exceeds `lag_hi_i`, and it is enabled only while that holds. The bench programs every limit pair in that order. The assertions also take the register inputs to be held steady around updates. The bench changes gains, codes and limits only between strobes, and it resets between configurations so that the discriminator history is known. Strobes, loads and timeouts are driven one at a time on the falling edge. The one deliberate overlap is a load together with a strobe, which exercises the priority rule.

// File: rtl/cl_pkg.sv
package cl_pkg;

    typedef enum logic [1:0] {
        SW_OFF  = 2'd0,
        SW_CONT = 2'd1,
        SW_STEP = 2'd2,
        SW_RSVD = 2'd3
    } sweep_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } fsm_e;

endpackage

// File: rtl/cl_gain_shift.sv
module cl_gain_shift #(
    parameter int IN_W   = 13,
    parameter int GAIN_W = 16,
    parameter int SHIFT  = 8,
    localparam int OUT_W = IN_W + GAIN_W + 1
) (
    input  logic [GAIN_W-1:0]       gain_i,
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] term_o
);
    logic signed [OUT_W-1:0] gain_ext;
    logic signed [OUT_W-1:0] val_ext;
    logic signed [OUT_W-1:0] prod;

    assign gain_ext = OUT_W'($signed({1'b0, gain_i}));
    assign val_ext  = OUT_W'(val_i);
    assign prod     = gain_ext * val_ext;
    assign term_o   = prod >>> SHIFT;
endmodule

// File: rtl/cl_freq_disc.sv
module cl_freq_disc #(
    parameter int ERR_W   = 12,
    parameter int MAX_LOG = 4,
    localparam int DEPTH  = 1 << MAX_LOG
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_i,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [2:0]              code_i,
    output logic signed [ERR_W:0]   ferr_o
);
    logic signed [ERR_W-1:0] tap_w [DEPTH];
    logic [MAX_LOG-1:0]      tap_idx;
    logic signed [ERR_W-1:0] old_err;

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic signed [ERR_W-1:0] q;
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (shift_i) q <= err_i;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n)       q <= '0;
                else if (shift_i) q <= tap_w[g-1];
            end
        end
        assign tap_w[g] = q;
    end

    always_comb begin
        if (code_i >= 3'(MAX_LOG)) tap_idx = MAX_LOG'(DEPTH - 1);
        else                       tap_idx = MAX_LOG'((1 << code_i) - 1);
    end

    assign old_err = tap_w[tap_idx];
    assign ferr_o  = $signed({err_i[ERR_W-1], err_i}) - $signed({old_err[ERR_W-1], old_err});

    // R5: newest history entry is the error accepted on the previous strobe
    p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (tap_w[0] == $past(err_i)));

    // R5: history holds between strobes
    p_hist_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(tap_w[DEPTH-1]));
endmodule

// File: rtl/cl_lag_acc.sv
module cl_lag_acc #(
    parameter int LAG_W = 24,
    parameter int KT_W  = 29,
    parameter int AT_W  = 30,
    parameter int SWP_W = 16,
    parameter int WIDE  = 56
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic signed [LAG_W-1:0] load_val_i,
    input  logic                    en_i,
    input  logic signed [KT_W-1:0]  kterm_i,
    input  logic signed [AT_W-1:0]  aterm_i,
    input  logic signed [SWP_W-1:0] sweep_i,
    input  logic signed [LAG_W-1:0] hi_i,
    input  logic signed [LAG_W-1:0] lo_i,
    output logic signed [LAG_W-1:0] lag_q,
    output logic signed [LAG_W-1:0] lag_next
);
    logic signed [WIDE-1:0] sum_w;
    logic signed [WIDE-1:0] hi_w;
    logic signed [WIDE-1:0] lo_w;

    assign sum_w = WIDE'(lag_q) + WIDE'(kterm_i) + WIDE'(aterm_i) + WIDE'(sweep_i);
    assign hi_w  = WIDE'(hi_i);
    assign lo_w  = WIDE'(lo_i);

    always_comb begin
        if (sum_w > hi_w)      lag_next = hi_i;
        else if (sum_w < lo_w) lag_next = lo_i;
        else                   lag_next = sum_w[LAG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      lag_q <= '0;
        else if (load_i) lag_q <= load_val_i;
        else if (en_i)   lag_q <= lag_next;
    end

    // R10: an update never leaves the accumulator outside the limits
    p_lag_in_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i && (lo_i <= hi_i)) |=>
            ((lag_q <= $past(hi_i)) && (lag_q >= $past(lo_i))));

    // R11: preset value appears the cycle after load
    p_load_preset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lag_q == $past(load_val_i)));
endmodule

// File: rtl/carrier_loop_afc.sv
module carrier_loop_afc #(
    parameter int ERR_W   = 12,
    parameter int GAIN_W  = 16,
    parameter int LAG_W   = 24,
    parameter int SWP_W   = 16,
    parameter int SHIFT   = 8,
    parameter int MAX_LOG = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      upd_i,
    input  logic signed [ERR_W-1:0]   err_i,
    input  logic                      load_i,
    input  logic signed [LAG_W-1:0]   load_val_i,
    input  logic                      tmo_i,
    input  logic                      trk_mode_i,
    input  logic                      afc_en_i,
    input  logic [GAIN_W-1:0]         afc_gain_acq_i,
    input  logic [GAIN_W-1:0]         afc_gain_trk_i,
    input  logic [2:0]                dly_code_i,
    input  logic [1:0]                sweep_sel_i,
    input  logic signed [SWP_W-1:0]   sweep_inc_i,
    input  logic [GAIN_W-1:0]         klag_i,
    input  logic [GAIN_W-1:0]         klead_i,
    input  logic signed [LAG_W-1:0]   lag_hi_i,
    input  logic signed [LAG_W-1:0]   lag_lo_i,
    output logic signed [LAG_W:0]     freq_o,
    output logic signed [LAG_W-1:0]   lag_o,
    output logic                      valid_o
);
    import cl_pkg::*;

    localparam int FERR_W = ERR_W + 1;
    localparam int KT_W   = ERR_W + GAIN_W + 1;
    localparam int AT_W   = FERR_W + GAIN_W + 1;
    localparam int OUT_W  = LAG_W + 1;
    localparam int WIDE   = LAG_W + GAIN_W + ERR_W + 4;

    fsm_e   state_q, state_d;
    sweep_e sweep_mode;
    logic   acq;
    logic   strobe;
    logic   step_hit;
    logic   acc_en;

    logic [GAIN_W-1:0]         klag_g;
    logic [GAIN_W-1:0]         afc_g;
    logic signed [FERR_W-1:0]  ferr;
    logic signed [KT_W-1:0]    kterm;
    logic signed [KT_W-1:0]    lead_term;
    logic signed [AT_W-1:0]    aterm;
    logic signed [SWP_W-1:0]   sweep_g;
    logic signed [LAG_W-1:0]   lag_q;
    logic signed [LAG_W-1:0]   lag_next;
    logic signed [WIDE-1:0]    osum;
    logic signed [OUT_W-1:0]   osat;
    logic signed [OUT_W-1:0]   freq_q;

    localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
    localparam logic signed [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};

    // ---------------- control decode ----------------
    assign sweep_mode = sweep_e'(sweep_sel_i);
    assign acq        = !trk_mode_i;
    assign strobe     = upd_i && !load_i;
    assign step_hit   = acq && (sweep_mode == SW_STEP) && tmo_i && !load_i;
    assign acc_en     = strobe || step_hit;

    assign klag_g = strobe ? klag_i : '0;

    always_comb begin
        if (!strobe || !afc_en_i) afc_g = '0;
        else if (acq)             afc_g = afc_gain_acq_i;
        else                      afc_g = afc_gain_trk_i;
    end

    always_comb begin
        sweep_g = '0;
        if (acq) begin
            unique case (sweep_mode)
                SW_CONT: if (strobe) sweep_g = sweep_inc_i;
                SW_STEP: if (tmo_i)  sweep_g = sweep_inc_i;
                SW_OFF, SW_RSVD: sweep_g = '0;
            endcase
        end
    end

    // ---------------- datapath pieces ----------------
    cl_freq_disc #(.ERR_W(ERR_W), .MAX_LOG(MAX_LOG)) u_disc (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift_i(strobe),
        .err_i  (err_i),
        .code_i (dly_code_i),
        .ferr_o (ferr)
    );

    cl_gain_shift #(.IN_W(ERR_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_klag (
        .gain_i(klag_g), .val_i(err_i), .term_o(kterm)
    );

    cl_gain_shift #(.IN_W(ERR_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_klead (
        .gain_i(klead_i), .val_i(err_i), .term_o(lead_term)
    );

    cl_gain_shift #(.IN_W(FERR_W), .GAIN_W(GAIN_W), .SHIFT(SHIFT)) u_kafc (
        .gain_i(afc_g), .val_i(ferr), .term_o(aterm)
    );

    cl_lag_acc #(.LAG_W(LAG_W), .KT_W(KT_W), .AT_W(AT_W), .SWP_W(SWP_W), .WIDE(WIDE)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .load_val_i(load_val_i),
        .en_i      (acc_en),
        .kterm_i   (kterm),
        .aterm_i   (aterm),
        .sweep_i   (sweep_g),
        .hi_i      (lag_hi_i),
        .lo_i      (lag_lo_i),
        .lag_q     (lag_q),
        .lag_next  (lag_next)
    );

    assign osum = WIDE'(lag_next) + WIDE'(lead_term);

    always_comb begin
        if (osum > WIDE'(OMAX))      osat = OMAX;
        else if (osum < WIDE'(OMIN)) osat = OMIN;
        else                         osat = osum[OUT_W-1:0];
    end

    // ---------------- sequencing FSM ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strobe)  state_d = ST_OUT;   // T_UPDATE
            ST_OUT:  if (!strobe) state_d = ST_IDLE;  // T_RETIRE
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      freq_q <= '0;
        else if (strobe) freq_q <= osat;
    end

    assign freq_o  = freq_q;
    assign lag_o   = lag_q;
    assign valid_o = (state_q == ST_OUT);

    // R2: valid follows accepted strobes by exactly one cycle
    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> valid_o);
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_i && !load_i) |=> !valid_o);

    // R3: output word holds between strobes
    p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_i && !load_i) |=> $stable(freq_o));

    // R9: lag idle with no strobe, load or timeout
    p_lag_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_i && !load_i && !tmo_i) |=> $stable(lag_o));
endmodule

// File: tb/carrier_loop_afc_bench.sv
module carrier_loop_afc_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               upd = 1'b0;
    logic signed [11:0] err = '0;
    logic               load = 1'b0;
    logic signed [23:0] load_val = '0;
    logic               tmo = 1'b0;
    logic               trk = 1'b0;
    logic               afc_en = 1'b0;
    logic [15:0]        g_acq = '0;
    logic [15:0]        g_trk = '0;
    logic [2:0]         code = '0;
    logic [1:0]         ssel = '0;
    logic signed [15:0] sinc = '0;
    logic [15:0]        klag = '0;
    logic [15:0]        klead = '0;
    logic signed [23:0] hi = 24'sh7FFFFF;
    logic signed [23:0] lo = -24'sd8388608;
    logic signed [24:0] freq;
    logic signed [23:0] lag;
    logic               valid;

    int n_chk = 0;
    int n_err = 0;
    longint m_lag;
    longint m_out;
    longint hist [16];

    always #4 clk = ~clk;

    carrier_loop_afc u_carrier_loop_afc (
        .clk(clk), .rst_n(rst_n), .upd_i(upd), .err_i(err), .load_i(load),
        .load_val_i(load_val), .tmo_i(tmo), .trk_mode_i(trk), .afc_en_i(afc_en),
        .afc_gain_acq_i(g_acq), .afc_gain_trk_i(g_trk), .dly_code_i(code),
        .sweep_sel_i(ssel), .sweep_inc_i(sinc), .klag_i(klag), .klead_i(klead),
        .lag_hi_i(hi), .lag_lo_i(lo), .freq_o(freq), .lag_o(lag), .valid_o(valid)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic longint clampv(input longint v, input longint l, input longint h);
        if (v > h) return h;
        if (v < l) return l;
        return v;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lag = 0;
        m_out = 0;
        for (int i = 0; i < 16; i++) hist[i] = 0;
    endtask

    task automatic model_upd(input longint e);
        longint fe, g, at, sw, d;
        d  = (code >= 3'd4) ? 16 : (longint'(1) << code);
        fe = e - hist[d-1];
        for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = e;
        g  = trk ? longint'(g_trk) : longint'(g_acq);
        at = afc_en ? ((g * fe) >>> 8) : 0;
        sw = (!trk && ssel == 2'd1) ? longint'(sinc) : 0;
        m_lag = clampv(m_lag + ((longint'(klag) * e) >>> 8) + at + sw, longint'(lo), longint'(hi));
        m_out = clampv(m_lag + ((longint'(klead) * e) >>> 8), -(longint'(1) << 24), (longint'(1) << 24) - 1);
    endtask

    task automatic do_upd(input string req, input int e);
        err = 12'(e);
        upd = 1'b1;
        @(negedge clk);
        upd = 1'b0;
        model_upd(longint'(e));
        chk(req, "valid", longint'(valid), 1);
        chk(req, "freq", longint'(freq), m_out);
        chk(req, "lag", longint'(lag), m_lag);
    endtask

    task automatic do_tmo(input string req);
        tmo = 1'b1;
        @(negedge clk);
        tmo = 1'b0;
        if (!trk && ssel == 2'd2) m_lag = clampv(m_lag + longint'(sinc), longint'(lo), longint'(hi));
        chk(req, "lag after timeout", longint'(lag), m_lag);
        chk(req, "valid after timeout", longint'(valid), 0);
    endtask

    task automatic do_load(input string req, input int v, input logic with_upd);
        load = 1'b1;
        load_val = 24'(v);
        upd = with_upd;
        @(negedge clk);
        load = 1'b0;
        upd = 1'b0;
        m_lag = longint'(v);
        chk(req, "lag after load", longint'(lag), m_lag);
        chk(req, "valid after load", longint'(valid), 0);
        chk(req, "freq held on load", longint'(freq), m_out);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R2 watchdog expired: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        chk("R1", "freq", longint'(freq), 0);
        chk("R1", "lag", longint'(lag), 0);
        chk("R1", "valid", longint'(valid), 0);

        // R5 R6 R4: every delay code in both modes
        for (int c = 0; c < 8; c++) begin
            for (int t = 0; t < 2; t++) begin
                do_reset();
                code = 3'(c); trk = t[0]; afc_en = 1'b1;
                g_acq = 16'd300; g_trk = 16'd170; klag = 16'd64; klead = 16'd0; ssel = 2'd0;
                for (int i = 0; i < 40; i++) do_upd("R5", ((i * 53 + c * 7) % 401) - 200);
                @(negedge clk);
                chk("R2", "valid drops", longint'(valid), 0);
                chk("R2", "freq held", longint'(freq), m_out);
            end
        end

        // R6: disabled term has no effect in either mode
        for (int t = 0; t < 2; t++) begin
            do_reset();
            trk = t[0]; afc_en = 1'b0; klag = 16'd0; code = 3'd2;
            for (int i = 0; i < 20; i++) do_upd("R6", (i * 97 % 301) - 150);
            chk("R6", "lag untouched", longint'(lag), 0);
        end

        // R7: zero track gain, non-zero acquire gain
        do_reset();
        afc_en = 1'b1; g_acq = 16'd500; g_trk = 16'd0; klag = 16'd0; trk = 1'b1; code = 3'd0;
        for (int i = 0; i < 10; i++) do_upd("R7", i * 40 - 180);
        chk("R7", "track lag unchanged", longint'(lag), 0);
        trk = 1'b0;
        for (int i = 0; i < 10; i++) do_upd("R7", 200 - i * 33);

        // R8: continuous sweep in acquire, none in track
        do_reset();
        afc_en = 1'b0; ssel = 2'd1; sinc = 16'sd1000; trk = 1'b0;
        for (int i = 0; i < 6; i++) do_upd("R8", 0);
        chk("R8", "six sweeps", longint'(lag), 6000);
        trk = 1'b1;
        for (int i = 0; i < 4; i++) do_upd("R8", 0);
        chk("R8", "no sweep in track", longint'(lag), 6000);
        do_tmo("R9");

        // R9: stepped sweep only on timeout
        do_reset();
        trk = 1'b0; ssel = 2'd2; sinc = 16'sd750; klag = 16'd20;
        for (int i = 0; i < 5; i++) do_upd("R9", 100);
        do_tmo("R9");
        do_tmo("R9");
        for (int i = 0; i < 3; i++) do_upd("R9", -60);
        ssel = 2'd3;
        do_tmo("R9");
        do_upd("R9", 10);
        ssel = 2'd0;
        do_tmo("R9");

        // R10: saturation both ways
        do_reset();
        klag = 16'd0; ssel = 2'd1; hi = 24'sd5000; lo = -24'sd3000; sinc = 16'sd1000;
        for (int i = 0; i < 8; i++) do_upd("R10", 0);
        chk("R10", "upper clamp", longint'(lag), 5000);
        sinc = -16'sd1500;
        for (int i = 0; i < 8; i++) do_upd("R10", 0);
        chk("R10", "lower clamp", longint'(lag), -3000);

        // R11: load, and load beating a strobe
        hi = 24'sh7FFFFF; lo = -24'sd8388608; ssel = 2'd0; klag = 16'd10;
        do_load("R11", 12345, 1'b0);
        do_upd("R11", 50);
        do_load("R11", -777, 1'b1);
        do_upd("R11", -50);

        // R3: lead path with extreme errors
        do_reset();
        klead = 16'd200; klag = 16'd30; afc_en = 1'b1; g_acq = 16'd40; code = 3'd1; trk = 1'b0;
        do_upd("R3", 2047);
        do_upd("R3", -2048);
        for (int i = 0; i < 20; i++) do_upd("R3", (i * 211 % 4096) - 2048);
        klead = 16'hFFFF;
        do_load("R3", 8388000, 1'b0);
        hi = 24'sh7FFFFF;
        do_upd("R3", 2047);
        do_upd("R3", -2048);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule